// File: doc/BRIEF.md
# Lockstep Result Checker with Checkpoint Rollback

This block sits beside two copies of an execution pipeline that run the same instruction stream in lockstep. Each cycle it receives both copies' result buses, a valid flag, a commit strobe and a destination index. When the two results agree on a committing cycle, the value is written into a protected checkpoint file. The file holds one word for each architected register plus a status word.

A disagreement starts a fixed rollback sequence. First the processor arrays are wiped, one entry per cycle. Next a single-cycle pulse resets the critical latches. The working registers are then rewritten one per cycle from the checkpoint, and finally instruction fetch is restarted. After the restart the block watches a window of committed instructions. A second disagreement inside that window marks the fault as hard. The block then sets a sticky fault flag and streams the checkpoint out on a valid/ready port, so that a spare processor can take over the work.

Top module: `lockstep_recovery`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every strobe output is 0, `rec_count` is 0 and `hard_fault` is 0. Every checkpoint word resets to 0.
- R2: A cycle with `in_valid`=1, `in_commit`=1, `res_a`==`res_b` and `in_idx`<=NREG writes `res_a` into checkpoint word `in_idx`, but only in the idle or watch phase. Words 0..NREG-1 are registers and word NREG is the status word. Cycles with `in_commit`=0, cycles whose index is above NREG, and cycles whose results differ write nothing.
- R3: `in_valid`=1 with `res_a`!=`res_b` while idle starts recovery. From the next cycle on, `arr_clr_en` is high for ARRAY_N cycles, and `arr_clr_idx` counts from 0 to ARRAY_N-1.
- R4: In the cycle after the last clear cycle, `latch_rst` is high for exactly one cycle.
- R5: For the next NREG+1 cycles `wr_en` is high, `wr_idx` counts from 0 to NREG, and `wr_data` equals checkpoint word `wr_idx`.
- R6: In the cycle after the last reload cycle, `fetch_restart` is high for exactly one cycle. `busy` is high from the first clear cycle through the restart cycle and low after it.
- R7: While `busy` is high, commits and disagreements on the inputs are ignored and the checkpoint is not changed.
- R8: `rec_count` rises by one each time a recovery starts, and it saturates at its maximum value.
- R9: A disagreement before RETRY_K agreeing commits have been seen after the restart sets `hard_fault` in the next cycle and does not start a new recovery. Once RETRY_K agreeing commits have completed, a later disagreement is again treated as a soft error.
- R10: One cycle after `hard_fault` rises, `unl_valid` goes high. Checkpoint words 0..NREG are presented on `unl_data` in index order, so the status word comes last. Each word is held stable until `unl_ready` is high.
- R11: `unl_done` pulses for one cycle in the cycle after the final word is accepted. `unl_valid` is low from then on.
- R12: `hard_fault` stays set, and all later inputs are ignored, until reset.
- R13: When `in_valid`=0, differing result buses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | result buses carry a result this cycle |
| in_commit | input | 1 | the result is architected and may be checkpointed |
| in_idx | input | IDX_W | destination word; NREG selects the status word |
| res_a | input | DATA_W | result from pipeline copy A |
| res_b | input | DATA_W | result from pipeline copy B |
| arr_clr_en | output | 1 | array clear step active |
| arr_clr_idx | output | CLR_W | array entry being cleared |
| latch_rst | output | 1 | critical-latch reset pulse |
| wr_en | output | 1 | working-register reload write |
| wr_idx | output | IDX_W | working-register index being reloaded |
| wr_data | output | DATA_W | reload value |
| fetch_restart | output | 1 | restart instruction fetch pulse |
| busy | output | 1 | rollback in progress |
| unl_valid | output | 1 | unload word valid |
| unl_ready | input | 1 | receiver accepts the unload word |
| unl_data | output | DATA_W | unload word |
| unl_done | output | 1 | one-cycle pulse after the last unload word |
| hard_fault | output | 1 | sticky hard-fault flag |
| rec_count | output | CNT_W | saturating count of recoveries started |

## Verification
The bench drives every checkpoint index, including the status word and out-of-range indices. Each rollback is checked through the reload stream: a wrong word there shows that a non-committing, mismatching or busy-phase write leaked into the checkpoint. Disagreements are placed in three positions: one inside the retry window, which must escalate to a hard fault; one just after the window has closed, which must give a soft retry; and one while a sequence is running, which must be ignored. The unload port is driven with the ready signal low for one cycle on every word, which tells a correct hold apart from a skipped or repeated word. Repeated recoveries after a reset drive the counter into saturation.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RESET,
        ST_RELOAD,
        ST_RESTART,
        ST_WATCH,
        ST_FAULT,
        ST_UNLOAD
    } lsr_state_e;
endpackage

// File: rtl/lsr_cmp.sv
module lsr_cmp #(
    parameter int DATA_W = 64
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              agree,
    output logic              disagree
);
    always_comb begin
        agree    = valid && (a == b);
        disagree = valid && (a != b);
    end
endmodule

// File: rtl/lsr_ckpt_rf.sv
module lsr_ckpt_rf #(
    parameter int DATA_W = 64,
    parameter int WORDS  = 17,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (widx == IDX_W'(i))) mem_d[i] = wdata;
        end
        rdata = '0;
        for (int i = 0; i < WORDS; i++)
            if (ridx == IDX_W'(i)) rdata = mem_q[i];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++)
            mem_q[i] <= rst_n ? mem_d[i] : '0;
    end

    // R2
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (widx < IDX_W'(WORDS)));

    for (genvar g = 0; g < WORDS; g++) begin : g_hold
        // R7
        word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(mem_q[g]));
    end
endmodule

// File: rtl/lsr_seq.sv
module lsr_seq
    import lsr_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int ARRAY_N = 8,
    parameter int RETRY_K = 16,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(NREG + 1),
    localparam int CLR_W  = (ARRAY_N > 1) ? $clog2(ARRAY_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             agree,
    input  logic             disagree,
    input  logic             commit,
    input  logic             unl_ready,
    output lsr_state_e       state_o,
    output logic [IDX_W-1:0] word_idx,
    output logic [CLR_W-1:0] clr_idx,
    output logic             ck_we,
    output logic             fault,
    output logic             done,
    output logic [CNT_W-1:0] rec_cnt
);
    localparam int SA = $clog2(ARRAY_N + 1);
    localparam int SB = $clog2(NREG + 2);
    localparam int SC = $clog2(RETRY_K + 1);
    localparam int SAB = (SA > SB) ? SA : SB;
    localparam int SW = (SAB > SC) ? SAB : SC;

    typedef struct packed {
        lsr_state_e     state;
        logic [SW-1:0]  step;
        logic           fault;
        logic           done;
        logic [CNT_W-1:0] rec;
    } seq_t;

    seq_t q, d;
    logic good_commit;

    always_comb begin
        d = q;
        d.done = 1'b0;
        good_commit = agree && commit;
        ck_we = good_commit && ((q.state == ST_IDLE) || (q.state == ST_WATCH));
        case (q.state)
            ST_IDLE: if (disagree) begin
                d.state = ST_CLEAR;
                d.step  = '0;
                d.rec   = (q.rec == '1) ? q.rec : q.rec + 1'b1;
            end
            ST_CLEAR: begin
                if (q.step == SW'(ARRAY_N - 1)) begin
                    d.state = ST_RESET;
                    d.step  = '0;
                end else d.step = q.step + 1'b1;
            end
            ST_RESET: begin
                d.state = ST_RELOAD;
                d.step  = '0;
            end
            ST_RELOAD: begin
                if (q.step == SW'(NREG)) begin
                    d.state = ST_RESTART;
                    d.step  = '0;
                end else d.step = q.step + 1'b1;
            end
            ST_RESTART: begin
                d.state = ST_WATCH;
                d.step  = '0;
            end
            ST_WATCH: begin
                if (disagree) begin
                    d.state = ST_FAULT;
                    d.step  = '0;
                    d.fault = 1'b1;
                end else if (good_commit) begin
                    if (q.step == SW'(RETRY_K - 1)) begin
                        d.state = ST_IDLE;
                        d.step  = '0;
                    end else d.step = q.step + 1'b1;
                end
            end
            ST_FAULT: if (q.step == '0) begin
                d.state = ST_UNLOAD;
            end
            ST_UNLOAD: if (unl_ready) begin
                if (q.step == SW'(NREG)) begin
                    d.state = ST_FAULT;
                    d.step  = SW'(1);
                    d.done  = 1'b1;
                end else d.step = q.step + 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.step  <= '0;
            q.fault <= 1'b0;
            q.done  <= 1'b0;
            q.rec   <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.state;
    assign word_idx = q.step[IDX_W-1:0];
    assign clr_idx  = q.step[CLR_W-1:0];
    assign fault    = q.fault;
    assign done     = q.done;
    assign rec_cnt  = q.rec;

    // R4
    latch_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RESET) |-> ($past(q.state) == ST_CLEAR));
    // R6
    restart_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RESTART) |-> ($past(q.state) == ST_RELOAD));
    // R9
    retry_escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_WATCH) && disagree) |=> (q.fault && (q.state == ST_FAULT)));
    // R12
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fault |=> q.fault);
    // R8
    rec_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |=> (q.rec == $past(q.rec)));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/lockstep_recovery.sv
module lockstep_recovery
    import lsr_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NREG    = 16,
    parameter int ARRAY_N = 8,
    parameter int RETRY_K = 16,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(NREG + 1),
    localparam int CLR_W  = (ARRAY_N > 1) ? $clog2(ARRAY_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_commit,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] res_a,
    input  logic [DATA_W-1:0] res_b,
    output logic              arr_clr_en,
    output logic [CLR_W-1:0]  arr_clr_idx,
    output logic              latch_rst,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              fetch_restart,
    output logic              busy,
    output logic              unl_valid,
    input  logic              unl_ready,
    output logic [DATA_W-1:0] unl_data,
    output logic              unl_done,
    output logic              hard_fault,
    output logic [CNT_W-1:0]  rec_count
);
    logic             agree, disagree, ck_we, rf_we;
    logic [IDX_W-1:0] word_idx;
    logic [DATA_W-1:0] rdata;
    lsr_state_e       st;

    lsr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .valid(in_valid), .a(res_a), .b(res_b),
        .agree(agree), .disagree(disagree)
    );

    lsr_seq #(
        .NREG(NREG), .ARRAY_N(ARRAY_N), .RETRY_K(RETRY_K), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .agree(agree), .disagree(disagree),
        .commit(in_commit), .unl_ready(unl_ready), .state_o(st),
        .word_idx(word_idx), .clr_idx(arr_clr_idx), .ck_we(ck_we),
        .fault(hard_fault), .done(unl_done), .rec_cnt(rec_count)
    );

    assign rf_we = ck_we && (in_idx <= IDX_W'(NREG));

    lsr_ckpt_rf #(.DATA_W(DATA_W), .WORDS(NREG + 1), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(in_idx), .wdata(res_a),
        .ridx(word_idx), .rdata(rdata)
    );

    always_comb begin
        arr_clr_en    = (st == ST_CLEAR);
        latch_rst     = (st == ST_RESET);
        wr_en         = (st == ST_RELOAD);
        fetch_restart = (st == ST_RESTART);
        busy          = arr_clr_en || latch_rst || wr_en || fetch_restart;
        unl_valid     = (st == ST_UNLOAD);
        wr_idx        = word_idx;
        wr_data       = rdata;
        unl_data      = rdata;
    end

    // R7
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rf_we);
    // R10
    unload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_valid && !unl_ready) |=> (unl_valid && $stable(unl_data)));
    // R10
    unload_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unl_valid |-> hard_fault);
endmodule

// File: tb/lockstep_recovery_test.sv
module lockstep_recovery_test;
    localparam int DW = 16, NR = 4, AN = 3, RK = 3, CW = 2;
    localparam int IW = $clog2(NR + 1), AW = $clog2(AN);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, in_valid, in_commit, unl_ready;
    logic [IW-1:0] in_idx;
    logic [DW-1:0] res_a, res_b;
    logic arr_clr_en, latch_rst, wr_en, fetch_restart, busy;
    logic unl_valid, unl_done, hard_fault;
    logic [AW-1:0] arr_clr_idx;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data, unl_data;
    logic [CW-1:0] rec_count;

    lockstep_recovery #(.DATA_W(DW), .NREG(NR), .ARRAY_N(AN), .RETRY_K(RK), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_commit(in_commit),
        .in_idx(in_idx), .res_a(res_a), .res_b(res_b), .arr_clr_en(arr_clr_en),
        .arr_clr_idx(arr_clr_idx), .latch_rst(latch_rst), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .fetch_restart(fetch_restart),
        .busy(busy), .unl_valid(unl_valid), .unl_ready(unl_ready),
        .unl_data(unl_data), .unl_done(unl_done), .hard_fault(hard_fault),
        .rec_count(rec_count)
    );

    int checks = 0, fails = 0;
    logic [DW-1:0] model [NR + 1];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_commit = 1'b0; in_idx = '0;
        res_a = '0; res_b = '0;
    endtask

    task automatic commit(input int idx, input logic [DW-1:0] v);
        in_valid = 1'b1; in_commit = 1'b1; in_idx = IW'(idx);
        res_a = v; res_b = v;
        tick();
        idle_in();
        if (idx <= NR) model[idx] = v;
    endtask

    task automatic mismatch();
        in_valid = 1'b1; in_commit = 1'b1; in_idx = '0;
        res_a = 16'h0F0F; res_b = 16'h0F0E;
        tick();
        idle_in();
    endtask

    task automatic retry_commits(input logic [DW-1:0] base);
        for (int i = 0; i < RK; i++) commit(i % (NR + 1), base + DW'(i));
    endtask

    // called right after the mismatch edge; state is now the clear phase
    task automatic run_recovery(input int exp_rec);
        // R7: matching commit during clear must not reach the checkpoint
        in_valid = 1'b1; in_commit = 1'b1; in_idx = '0; res_a = 16'hBEEF; res_b = 16'hBEEF;
        for (int i = 0; i < AN; i++) begin
            chk("R3 clear enable", arr_clr_en, 1);
            chk("R3 clear index", arr_clr_idx, i);
            chk("R6 busy in clear", busy, 1);
            tick();
        end
        // R7: disagreement during sequence is ignored
        res_a = 16'h0001; res_b = 16'h0002;
        chk("R4 latch reset pulse", latch_rst, 1);
        chk("R4 clear ended", arr_clr_en, 0);
        tick();
        chk("R4 latch reset single", latch_rst, 0);
        for (int i = 0; i <= NR; i++) begin
            chk("R5 reload enable", wr_en, 1);
            chk("R5 reload index", wr_idx, i);
            chk("R5 R7 reload data", wr_data, model[i]);
            tick();
        end
        idle_in();
        chk("R6 restart pulse", fetch_restart, 1);
        chk("R6 reload ended", wr_en, 0);
        chk("R8 recovery count", rec_count, exp_rec);
        tick();
        chk("R6 restart single", fetch_restart, 0);
        chk("R6 busy released", busy, 0);
        chk("R9 no fault after soft retry", hard_fault, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i <= NR; i++) model[i] = '0;
        rst_n = 1'b0; unl_ready = 1'b0;
        idle_in();
        res_a = 16'h1; res_b = 16'h2; in_valid = 1'b1;
        repeat (3) tick();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset strobes", {arr_clr_en, latch_rst, wr_en, fetch_restart, unl_valid, unl_done}, 0);
        chk("R1 reset fault", hard_fault, 0);
        chk("R1 reset count", rec_count, 0);
        idle_in();
        rst_n = 1'b1;
        tick();
        chk("R1 first cycle busy", busy, 0);
        chk("R1 first cycle count", rec_count, 0);

        // R13: unequal buses without valid
        res_a = 16'h1234; res_b = 16'h4321;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R13 invalid ignored busy", busy, 0);
            chk("R13 invalid ignored count", rec_count, 0);
        end
        idle_in();

        // R2: fill every word including status
        for (int i = 0; i <= NR; i++) commit(i, 16'h1000 + DW'(i) * 16'h0111);
        commit(NR + 2, 16'hDEAD);                 // R2 out-of-range, ignored
        in_valid = 1'b1; in_commit = 1'b0; in_idx = '0; res_a = 16'h5555; res_b = 16'h5555;
        tick();                                   // R2 non-commit, ignored
        idle_in();

        mismatch();
        run_recovery(1);
        retry_commits(16'h2000);                  // window closes
        mismatch();                               // R9 soft again
        run_recovery(2);

        commit(1, 16'h3333);
        mismatch();                               // inside window
        chk("R9 hard fault set", hard_fault, 1);
        chk("R9 no new recovery", busy, 0);
        chk("R9 count unchanged", rec_count, 2);
        chk("R10 unload not yet", unl_valid, 0);
        tick();
        for (int i = 0; i <= NR; i++) begin
            unl_ready = 1'b0;
            chk("R10 unload valid", unl_valid, 1);
            chk("R10 unload word", unl_data, model[i]);
            tick();
            chk("R10 hold valid", unl_valid, 1);
            chk("R10 hold word", unl_data, model[i]);
            chk("R11 no early done", unl_done, 0);
            unl_ready = 1'b1;
            tick();
        end
        unl_ready = 1'b0;
        chk("R11 done pulse", unl_done, 1);
        chk("R11 valid dropped", unl_valid, 0);
        tick();
        chk("R11 done single", unl_done, 0);
        chk("R11 valid stays low", unl_valid, 0);
        mismatch();
        commit(0, 16'h7777);
        chk("R12 fault sticky", hard_fault, 1);
        chk("R12 no recovery", busy, 0);
        chk("R12 no unload", unl_valid, 0);
        chk("R12 count frozen", rec_count, 2);

        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        for (int i = 0; i <= NR; i++) model[i] = '0;  // R1 checkpoint cleared
        chk("R12 reset clears fault", hard_fault, 0);
        chk("R1 count cleared", rec_count, 0);

        // R8 saturation with a 2-bit counter; first reload checks R1 zeros
        mismatch(); run_recovery(1); retry_commits(16'h4000);
        mismatch(); run_recovery(2); retry_commits(16'h5000);
        mismatch(); run_recovery(3); retry_commits(16'h6000);
        mismatch(); run_recovery(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule